// File: doc/BRIEF.md
# DDR Read Latency and Strobe Generator

This block produces the read-side pin timing of a double-data-rate memory model. Each read request carries a start column, a burst length and a latency choice of two or three clocks. After that latency the block drives one data beat while the clock is high and the next while it is low. It frames the burst with a strobe that is held low for a clock beforehand, toggles in step with the clock while data is valid, and stays low for half a clock afterwards.

The beat values come from the column address. The start column sits inside an aligned block the size of the burst, and the beats count upward from it, wrapping inside that block. A request that arrives while earlier bursts are still pending or playing waits in a short queue. It then plays straight after its predecessor, with no idle clock, as soon as its own latency allows. Outside the framed window the block drives neither the data bus nor the strobe.

Top module: `ddr_rd_strobe_gen`

## Requirements
- R1: With `rd_lat`=0 (two-clock latency), a read sampled at rising edge n while nothing is pending or playing puts its first beat on `dq` at rising edge n+1.
- R2: With `rd_lat`=1 (three-clock latency), a read sampled at rising edge n while nothing is pending or playing puts its first beat on `dq` at rising edge n+2.
- R3: `rd_blen` selects 2, 4, 8 or 16 beats for codes 0, 1, 2 and 3. A burst of B beats takes B/2 clocks. Even beats are on `dq` while `clk` is high and odd beats while `clk` is low.
- R4: For start column C and B beats, beat j carries the value whose bits above log2(B) equal those of C and whose low log2(B) bits equal (C + j) mod B.
- R5: During the whole clock before a data clock that follows a non-data clock, `dqs_oe`=1 and `dqs`=0.
- R6: During every data clock, `dq_oe`=1 and `dqs`=1 while `clk` is high and 0 while `clk` is low.
- R7: In the first half of the clock after the last data clock, when no burst follows, `dqs_oe`=1 and `dqs`=0. In the second half of that clock, `dqs_oe` falls unless a preamble is due.
- R8: Outside the windows of R5, R6 and R7, `dq_oe` and `dqs_oe` are 0.
- R9: A queued read starts at the later of two edges: the edge its own latency gives, and the edge right after the previous burst's last data clock. Back-to-back bursts leave no gap and no preamble or postamble between them.
- R10: Up to QDEPTH reads (default 4) can wait for their start. A read that arrives when the queue is full, with no read leaving it on that edge, is dropped.
- R11: While `rst_n` is low, `dq_oe`, `dqs_oe` and `dqs` are 0 at once, even during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both phases carry data |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Read request, sampled on the rising edge |
| rd_lat | input | 1 | 0: two-clock latency, 1: three-clock latency |
| rd_blen | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=16 beats |
| rd_col | input | DW | Start column, which also gives the beat values |
| dq | output | DW | Read data beat |
| dq_oe | output | 1 | Data bus drive enable |
| dqs | output | 1 | Read strobe |
| dqs_oe | output | 1 | Strobe drive enable |

## Verification
The bench targets the latency boundary in both settings and the wrap of the column count inside the shortest and longest bursts. An off-by-one scheduler would shift the data a clock early or late. A wrong wrap would carry into the block bits. It also queues reads so that one lands exactly on the free edge and another lands after it. This exposes designs that insert a gap clock, or that put a preamble or postamble between joined bursts. It also exercises a three-clock read that merges a postamble with the next preamble, overruns the queue so that exactly one read must be dropped, and asserts reset in the middle of a burst, where a synchronous clear would leave the buses driven.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

   // burst length codes, beats = 2 << code
   typedef enum logic [1:0] {
      RD_BL2  = 2'd0,
      RD_BL4  = 2'd1,
      RD_BL8  = 2'd2,
      RD_BL16 = 2'd3
   } ddr_rd_blen_e;

   // read latency choice
   typedef enum logic {
      RD_CL2 = 1'b0,
      RD_CL3 = 1'b1
   } ddr_rd_lat_e;

   // clock counter width for the longest burst (8 clocks)
   localparam int RD_KW = 3;
   // countdown width for the latency wait
   localparam int RD_WW = 2;

endpackage

// File: rtl/ddr_rd_cmd_queue.sv
module ddr_rd_cmd_queue
   import ddr_rd_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push,
   input  logic [DW-1:0]       push_col,
   input  ddr_rd_blen_e        push_code,
   input  ddr_rd_lat_e         push_lat,
   input  logic                pop,
   output logic                head_vld,
   output logic [DW-1:0]       head_col,
   output ddr_rd_blen_e        head_code,
   output logic [RD_WW-1:0]    head_wait,
   output logic [CW-1:0]       cnt
);

   logic [DW-1:0]    col_q  [DEPTH];
   ddr_rd_blen_e     code_q [DEPTH];
   logic [RD_WW-1:0] wait_q [DEPTH];
   logic [DW-1:0]    col_n  [DEPTH];
   ddr_rd_blen_e     code_n [DEPTH];
   logic [RD_WW-1:0] wait_n [DEPTH];
   logic [CW-1:0]    cnt_q;
   logic             push_ok;
   logic [CW-1:0]    wr_idx;

   assign push_ok = push && ((cnt_q < CW'(DEPTH)) || pop);
   assign wr_idx  = cnt_q - CW'(pop);

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         int src;
         src = (pop && (i < DEPTH - 1)) ? i + 1 : i;
         col_n[i]  = col_q[src];
         code_n[i] = code_q[src];
         wait_n[i] = (wait_q[src] == '0) ? '0 : wait_q[src] - 1'b1;
         if (push_ok && (wr_idx == CW'(i))) begin
            col_n[i]  = push_col;
            code_n[i] = push_code;
            wait_n[i] = (push_lat == RD_CL3) ? RD_WW'(2) : RD_WW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            col_q[i]  <= '0;
            code_q[i] <= RD_BL2;
            wait_q[i] <= '0;
         end
      end else begin
         cnt_q <= cnt_q - CW'(pop) + CW'(push_ok);
         for (int i = 0; i < DEPTH; i++) begin
            col_q[i]  <= col_n[i];
            code_q[i] <= code_n[i];
            wait_q[i] <= wait_n[i];
         end
      end
   end

   assign head_vld  = (cnt_q != '0);
   assign head_col  = col_q[0];
   assign head_code = code_q[0];
   assign head_wait = wait_q[0];
   assign cnt       = cnt_q;

endmodule

// File: rtl/ddr_rd_burst_engine.sv
module ddr_rd_burst_engine
   import ddr_rd_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_vld,
   input  logic [DW-1:0]    head_col,
   input  ddr_rd_blen_e     head_code,
   input  logic [RD_WW-1:0] head_wait,
   output logic             pop,
   output logic             act,
   output logic             pre,
   output logic             post,
   output logic [DW-1:0]    beat_even,
   output logic [DW-1:0]    beat_odd
);

   logic             act_q;
   logic             post_q;
   logic [RD_KW-1:0] k_q;
   logic [DW-1:0]    col_q;
   ddr_rd_blen_e     code_q;
   logic [RD_KW-1:0] len_m1;
   logic [DW-1:0]    mask;
   logic             last;
   logic             start;

   always_comb begin
      case (code_q)
         RD_BL2:  len_m1 = RD_KW'(0);
         RD_BL4:  len_m1 = RD_KW'(1);
         RD_BL8:  len_m1 = RD_KW'(3);
         default: len_m1 = RD_KW'(7);
      endcase
   end

   // low bits that wrap inside the aligned block
   assign mask  = DW'({code_q == RD_BL16, code_q >= RD_BL8, code_q >= RD_BL4, 1'b1});
   assign last  = act_q && (k_q == len_m1);
   assign start = head_vld && (head_wait <= RD_WW'(1)) && (!act_q || last);

   assign beat_even = (col_q & ~mask) | ((col_q + DW'({k_q, 1'b0})) & mask);
   assign beat_odd  = (col_q & ~mask) | ((col_q + DW'({k_q, 1'b1})) & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         post_q <= 1'b0;
         k_q    <= '0;
         col_q  <= '0;
         code_q <= RD_BL2;
      end else begin
         post_q <= last && !start;
         if (start) begin
            act_q  <= 1'b1;
            k_q    <= '0;
            col_q  <= head_col;
            code_q <= head_code;
         end else if (last) begin
            act_q <= 1'b0;
         end else if (act_q) begin
            k_q <= k_q + 1'b1;
         end
      end
   end

   assign pop  = start;
   assign act  = act_q;
   assign post = post_q;
   assign pre  = !act_q && head_vld && (head_wait == RD_WW'(1));

endmodule

// File: rtl/ddr_rd_phase_mux.sv
module ddr_rd_phase_mux #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          act,
   input  logic          pre,
   input  logic          post,
   input  logic [DW-1:0] beat_even,
   input  logic [DW-1:0] beat_odd,
   output logic [DW-1:0] dq,
   output logic          dq_oe,
   output logic          dqs,
   output logic          dqs_oe
);

   assign dq     = clk ? beat_even : beat_odd;
   assign dq_oe  = act;
   assign dqs    = act & clk;
   assign dqs_oe = act | pre | (post & clk);

endmodule

// File: rtl/ddr_rd_strobe_gen.sv
module ddr_rd_strobe_gen
   import ddr_rd_pkg::*;
#(
   parameter int DW     = 16,
   parameter int QDEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_cmd,
   input  logic          rd_lat,
   input  logic [1:0]    rd_blen,
   input  logic [DW-1:0] rd_col,
   output logic [DW-1:0] dq,
   output logic          dq_oe,
   output logic          dqs,
   output logic          dqs_oe
);

   localparam int CW = $clog2(QDEPTH + 1);

   if (DW < 4) begin : g_bad_dw
      $error("ddr_rd_strobe_gen: DW must cover the 16-beat wrap field");
   end
   if (QDEPTH < 1) begin : g_bad_depth
      $error("ddr_rd_strobe_gen: QDEPTH must be at least 1");
   end

   logic             head_vld;
   logic [DW-1:0]    head_col;
   ddr_rd_blen_e     head_code;
   logic [RD_WW-1:0] head_wait;
   logic [CW-1:0]    q_cnt;
   logic             pop;
   logic             eng_act;
   logic             eng_pre;
   logic             eng_post;
   logic [DW-1:0]    beat_even;
   logic [DW-1:0]    beat_odd;

   ddr_rd_cmd_queue #(.DW(DW), .DEPTH(QDEPTH)) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rd_cmd),
      .push_col  (rd_col),
      .push_code (ddr_rd_blen_e'(rd_blen)),
      .push_lat  (ddr_rd_lat_e'(rd_lat)),
      .pop       (pop),
      .head_vld  (head_vld),
      .head_col  (head_col),
      .head_code (head_code),
      .head_wait (head_wait),
      .cnt       (q_cnt)
   );

   ddr_rd_burst_engine #(.DW(DW)) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .head_vld  (head_vld),
      .head_col  (head_col),
      .head_code (head_code),
      .head_wait (head_wait),
      .pop       (pop),
      .act       (eng_act),
      .pre       (eng_pre),
      .post      (eng_post),
      .beat_even (beat_even),
      .beat_odd  (beat_odd)
   );

   ddr_rd_phase_mux #(.DW(DW)) i_phase (
      .clk       (clk),
      .act       (eng_act),
      .pre       (eng_pre),
      .post      (eng_post),
      .beat_even (beat_even),
      .beat_odd  (beat_odd),
      .dq        (dq),
      .dq_oe     (dq_oe),
      .dqs       (dqs),
      .dqs_oe    (dqs_oe)
   );

endmodule

// File: rtl/ddr_rd_strobe_chk.sv
module ddr_rd_strobe_chk #(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_cmd,
   input logic          rd_lat,
   input logic          dq_oe,
   input logic          dqs,
   input logic          dqs_oe,
   input logic [CW-1:0] q_cnt,
   input logic          eng_act
);

   AST_CL2_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && !rd_lat && q_cnt == '0 && !eng_act) |=> (dqs_oe && !dq_oe) ##1 dq_oe); // R1

   AST_CL3_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && rd_lat && q_cnt == '0 && !eng_act) |=> !dq_oe ##1 (dqs_oe && !dq_oe) ##1 dq_oe); // R2

   AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> $past(dqs_oe)); // R5

   AST_STROBE_HIGH_PHASE: assert property (@(negedge clk) disable iff (!rst_n)
      dq_oe |-> (dqs && dqs_oe)); // R6

   AST_POSTAMBLE_LOW: assert property (@(negedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> (dqs_oe && !dqs)); // R7

   AST_DATA_NEEDS_STROBE: assert property (@(negedge clk) disable iff (!rst_n)
      !dqs_oe |-> !dq_oe); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CW'(DEPTH)); // R10

endmodule

bind ddr_rd_strobe_gen ddr_rd_strobe_chk #(.DEPTH(QDEPTH)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_cmd  (rd_cmd),
   .rd_lat  (rd_lat),
   .dq_oe   (dq_oe),
   .dqs     (dqs),
   .dqs_oe  (dqs_oe),
   .q_cnt   (q_cnt),
   .eng_act (eng_act)
);

// File: tb/test_ddr_rd_strobe_gen.sv
`timescale 1ns/1ps
module test_ddr_rd_strobe_gen;

   localparam int DW   = 16;
   localparam int QD   = 4;
   localparam int MAXC = 64;
   localparam int MAXQ = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_cmd = 1'b0;
   logic          rd_lat = 1'b0;
   logic [1:0]    rd_blen = 2'd0;
   logic [DW-1:0] rd_col = '0;
   logic [DW-1:0] dq;
   logic          dq_oe;
   logic          dqs;
   logic          dqs_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   int            cmd_cyc  [MAXQ];
   logic [DW-1:0] cmd_col  [MAXQ];
   int            cmd_code [MAXQ];
   int            cmd_lat  [MAXQ];
   int            n_cmd;

   logic [2:0]    s_ctl_h [MAXC];
   logic [2:0]    s_ctl_l [MAXC];
   logic [DW-1:0] s_dq_h  [MAXC];
   logic [DW-1:0] s_dq_l  [MAXC];

   always #2.5 clk = ~clk;

   ddr_rd_strobe_gen #(.DW(DW), .QDEPTH(QD)) i_ddr_rd_strobe_gen (
      .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_lat(rd_lat),
      .rd_blen(rd_blen), .rd_col(rd_col), .dq(dq), .dq_oe(dq_oe),
      .dqs(dqs), .dqs_oe(dqs_oe)
   );

   function automatic logic [DW-1:0] exp_col(logic [DW-1:0] base, int code, int j);
      logic [DW-1:0] m;
      m = DW'((2 << code) - 1);
      return (base & ~m) | ((base + DW'(j)) & m);
   endfunction

   task automatic clr_cmds();
      n_cmd = 0;
   endtask

   task automatic add_cmd(int c, logic [DW-1:0] col, int code, int lat);
      cmd_cyc[n_cmd]  = c;
      cmd_col[n_cmd]  = col;
      cmd_code[n_cmd] = code;
      cmd_lat[n_cmd]  = lat;
      n_cmd++;
   endtask

   // leaves time 1.25 ns after a falling edge
   task automatic do_reset();
      rd_cmd = 1'b0;
      rst_n  = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1.25;
      rst_n = 1'b1;
   endtask

   task automatic run_scn(string tag, int ncyc);
      bit            d  [MAXC+1];
      logic [DW-1:0] ce [MAXC];
      logic [DW-1:0] co [MAXC];
      int            st [MAXQ];
      bit            acc[MAXQ];
      int            free_e;
      do_reset();
      for (int c = 0; c < ncyc; c++) begin
         rd_cmd = 1'b0;
         for (int i = 0; i < n_cmd; i++) begin
            if (cmd_cyc[i] == c) begin
               rd_cmd  = 1'b1;
               rd_col  = cmd_col[i];
               rd_blen = 2'(cmd_code[i]);
               rd_lat  = 1'(cmd_lat[i]);
            end
         end
         @(posedge clk);
         #1.25;
         s_ctl_h[c] = {dq_oe, dqs_oe, dqs};
         s_dq_h[c]  = dq;
         @(negedge clk);
         #1.25;
         s_ctl_l[c] = {dq_oe, dqs_oe, dqs};
         s_dq_l[c]  = dq;
      end
      rd_cmd = 1'b0;
      // model of the schedule
      for (int c = 0; c <= MAXC; c++) d[c] = 1'b0;
      for (int c = 0; c < MAXC; c++) begin ce[c] = '0; co[c] = '0; end
      free_e = 0;
      for (int i = 0; i < n_cmd; i++) begin
         int occ;
         occ = 0;
         for (int j = 0; j < i; j++)
            if (acc[j] && st[j] > cmd_cyc[i]) occ++;
         acc[i] = (occ < QD);
         st[i]  = 0;
         if (acc[i]) begin
            int s;
            s = cmd_cyc[i] + ((cmd_lat[i] != 0) ? 2 : 1);
            if (s < free_e) s = free_e;
            st[i] = s;
            for (int k = 0; k < (1 << cmd_code[i]); k++) begin
               if (s + k < MAXC) begin
                  d[s+k]  = 1'b1;
                  ce[s+k] = exp_col(cmd_col[i], cmd_code[i], 2*k);
                  co[s+k] = exp_col(cmd_col[i], cmd_code[i], 2*k+1);
               end
            end
            free_e = s + (1 << cmd_code[i]);
         end
      end
      for (int c = 0; c < ncyc; c++) begin
         bit pre, post, ok;
         logic [2:0] eh, el;
         pre  = !d[c] && d[c+1];
         post = (c > 0) && d[c-1] && !d[c];
         eh = {d[c], d[c] | pre | post, d[c]};
         el = {d[c], d[c] | pre, 1'b0};
         ok = (s_ctl_h[c] == eh) && (s_ctl_l[c] == el) &&
              (!d[c] || (s_dq_h[c] == ce[c] && s_dq_l[c] == co[c]));
         n_chk++;
         if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got oe/dqs_oe/dqs h=%b l=%b dq h=%h l=%h, expected h=%b l=%b dq h=%h l=%h",
                     tag, c, s_ctl_h[c], s_ctl_l[c], s_dq_h[c], s_dq_l[c], eh, el, ce[c], co[c]);
         end
      end
   endtask

   // R11: reset in the middle of a burst releases the buses at once
   task automatic t_reset_mid_burst();
      do_reset();
      rd_cmd = 1'b1; rd_lat = 1'b0; rd_blen = 2'd3; rd_col = 16'h0040;
      @(posedge clk);
      #1.25;
      rd_cmd = 1'b0;
      @(posedge clk);
      #1.25;
      rst_n = 1'b0;
      #0.5;
      n_chk++;
      if ({dq_oe, dqs_oe, dqs} != 3'b000) begin
         n_bad++;
         $display("FAIL R11 async clear: got oe/dqs_oe/dqs=%b, expected 000", {dq_oe, dqs_oe, dqs});
      end
      @(posedge clk);
      #1.25;
      n_chk++;
      if ({dq_oe, dqs_oe, dqs} != 3'b000) begin
         n_bad++;
         $display("FAIL R11 held in reset: got oe/dqs_oe/dqs=%b, expected 000", {dq_oe, dqs_oe, dqs});
      end
      @(negedge clk);
      #1.25;
      rst_n = 1'b1;
   endtask

   task automatic t_cl2_single();
      clr_cmds();
      add_cmd(1, 16'h0005, 1, 0);
      run_scn("R1 R3 R4 R5 R6 R7 R8", 8);
   endtask

   task automatic t_cl3_single();
      clr_cmds();
      add_cmd(1, 16'h001D, 2, 1);
      run_scn("R2 R4 R5 R6 R7 R8", 10);
   endtask

   task automatic t_lengths();
      clr_cmds();
      add_cmd(1, 16'h0013, 0, 0);
      add_cmd(6, 16'h00AB, 3, 1);
      run_scn("R3 R4", 20);
   endtask

   task automatic t_back2back();
      clr_cmds();
      add_cmd(1, 16'h0100, 1, 0);
      add_cmd(2, 16'h0207, 1, 0);
      add_cmd(4, 16'h0301, 0, 1);
      add_cmd(6, 16'h0412, 2, 0);
      run_scn("R9", 16);
   endtask

   task automatic t_gap_merge();
      clr_cmds();
      add_cmd(1, 16'h0A0E, 1, 0);
      add_cmd(3, 16'h0B03, 1, 1);
      run_scn("R5 R7 R9", 10);
   endtask

   task automatic t_overflow();
      clr_cmds();
      for (int i = 0; i < 6; i++) add_cmd(1 + i, DW'(16'h1000 * (i + 1) + 5), 3, 0);
      run_scn("R10", 46);
   endtask

   initial begin
      t_reset_mid_burst();
      t_cl2_single();
      t_cl3_single();
      t_lengths();
      t_back2back();
      t_gap_merge();
      t_overflow();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired before the last scenario finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule